// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Controller

This block drives two pulse-width-modulated outputs from a single system clock. Software sets it up through a small 32-bit register bus with plain read and write strobes. Each channel first divides the clock through a prescaler. The prescaler takes a 4-bit code that selects a ratio from a fixed, non-linear table, or passes the clock straight through. The prescaled ticks then drive a period counter. The output is active for the first part of each period, and that part is set by a duty count.

One shared control word holds, for both channels, the prescaler code, the run enable, the output polarity and the clock gate. Each channel also has its own word for period and duty. A new period/duty word written while the channel runs is held back until the current period ends. During that time a per-channel pending flag is visible in the control word, so software can tell when the new value has taken effect.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: Register map, using byte addresses with word index `bus_addr[3:2]`:
  - Word 0 (address 0x0) is the control word. Word 1+n (address 0x4 + 4n) is the period/duty word of channel n.
  - Reads return the stored value while `bus_rd` is high. `bus_rdata` is 0 while `bus_rd` is low.
  - The unused word 3 (address 0xC) reads 0 and ignores writes.
- R2: Control word layout. Channel n owns bits 15n+9 .. 15n:
  - bits 3:0 are the prescaler code, bit 4 the run enable, bit 5 the polarity, bit 6 the clock gate.
  - Bits 9:7 are stored and read back but have no effect.
  - Bit 28+n is channel n's pending flag. It is read-only, and all other control bits read 0.
- R3: Prescaler codes map to divide ratios as follows: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, and 15→1 (bypass).
- R4: A channel runs only while both its run enable and its clock gate are 1.
- R5: In a period/duty word, bits 31:16 hold the period length minus one (P) and bits 15:0 hold the duty count (D). A running channel repeats a cycle of P+1 ticks and is active during the first D ticks.
- R6: Writes to the period/duty word:
  - A write while the channel runs sets the pending flag. The new value takes effect at the next period end, and the flag clears then.
  - If the write lands on the same clock as a period end, it waits for the following one.
  - A write while the channel is stopped takes effect at once and leaves the flag clear.
- R7: If D ≥ P+1, the output is active for the whole period. If D = 0, it is never active.
- R8: With polarity 1 the active level is high. With polarity 0 the output is inverted, so it is low while active.
- R9: A stopped channel rests at its inactive level. When it is started again, its prescaler and period count restart from zero, so the first D ticks after the enabling write are active.
- R10: Codes 5, 6, 7, 13 and 14 are invalid. While such a code is selected, the channel produces no ticks: its output and count hold, and any pending value stays pending.
- R11: After reset every register is 0, both pending flags are clear, and both outputs are high (inactive level at polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, gates `bus_rdata` |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pwm_out | output | 2 | Channel outputs, bit n is channel n |

## Verification
The hardest situation to reach from the ports is a period/duty write that lands exactly on a period end of a running channel. That write must stay pending for a full extra period rather than load at once. The bench reaches it by starting from a stopped channel in bypass mode, where the count is known cycle by cycle after the enabling write, and placing the next write on the clock where the count wraps. A behavioural model run alongside the design checks the output and readback on every clock. This covers the long prescaler ratios and the stall on invalid codes.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int NCH       = 2;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int PS_W      = 17;
    localparam int FIELD_W   = 10;
    localparam int CH_STRIDE = 15;
    localparam int BUSY_BASE = 28;

    // Per-channel control field, LSB first: code, enable, polarity, gate, spare.
    typedef struct packed {
        logic [2:0] spare;
        logic       gate;
        logic       act;
        logic       en;
        logic [3:0] code;
    } ch_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] prd_m1;
        logic [CNT_W-1:0] duty;
    } pd_word_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PD
    } reg_sel_e;

    // Divide ratio for a prescaler code; zero marks an invalid code.
    function automatic logic [PS_W-1:0] div_ratio(input logic [3:0] code);
        case (code)
            4'd0:    return PS_W'(120);
            4'd1:    return PS_W'(180);
            4'd2:    return PS_W'(240);
            4'd3:    return PS_W'(360);
            4'd4:    return PS_W'(480);
            4'd8:    return PS_W'(12000);
            4'd9:    return PS_W'(24000);
            4'd10:   return PS_W'(36000);
            4'd11:   return PS_W'(48000);
            4'd12:   return PS_W'(72000);
            4'd15:   return PS_W'(1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NCH-1:0]            busy,
    input  pd_word_t [NCH-1:0]        pd_shadow,
    output ch_cfg_t  [NCH-1:0]        cfg,
    output logic [NCH-1:0]            pd_we
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word;
    reg_sel_e          sel;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] rd_val;
    logic              unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    always_comb begin
        if (word == '0)
            sel = SEL_CTRL;
        else if (word <= IDX_W'(NCH))
            sel = SEL_PD;
        else
            sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_wr && sel == SEL_CTRL) begin
            for (int c = 0; c < NCH; c++)
                cfg[c] <= ch_cfg_t'(bus_wdata[c*CH_STRIDE +: FIELD_W]);
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            pd_we[c] = bus_wr && sel == SEL_PD && word == IDX_W'(c + 1);
    end

    always_comb begin
        ctrl_rd = '0;
        for (int c = 0; c < NCH; c++) begin
            ctrl_rd[c*CH_STRIDE +: FIELD_W] = cfg[c];
            ctrl_rd[BUSY_BASE + c]          = busy[c];
        end
        rd_val = '0;
        if (sel == SEL_CTRL) begin
            rd_val = ctrl_rd;
        end else if (sel == SEL_PD) begin
            for (int c = 0; c < NCH; c++)
                if (word == IDX_W'(c + 1))
                    rd_val = pd_shadow[c];
        end
        bus_rdata = bus_rd ? rd_val : '0;
    end

endmodule

// File: rtl/pwm_pair_presc.sv
module pwm_pair_presc
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick,
    output logic       bad_code
);

    logic [PS_W-1:0] div;
    logic [PS_W-1:0] pc_q;

    assign div      = div_ratio(code);
    assign bad_code = (div == '0);
    // ">=" lets a running ratio shrink without a long wrap-around.
    assign tick     = run && !bad_code && (pc_q >= div - PS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || bad_code || tick)
            pc_q <= '0;
        else
            pc_q <= pc_q + PS_W'(1);
    end

endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             act,
    input  logic             pd_we,
    input  pd_word_t         pd_wdata,
    output pd_word_t         shadow,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] wk_prd,
    output logic             pwm
);

    pd_word_t working;
    logic     wrap;
    logic     hit;

    assign wrap   = (cnt == working.prd_m1);
    assign wk_prd = working.prd_m1;
    assign hit    = run && (cnt < working.duty);
    assign pwm    = act ? hit : !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            working <= '0;
            busy    <= 1'b0;
        end else if (pd_we) begin
            shadow <= pd_wdata;
            if (!run) begin
                working <= pd_wdata;
                busy    <= 1'b0;
            end else begin
                busy <= 1'b1;
            end
        end else if (!run) begin
            working <= shadow;
            busy    <= 1'b0;
        end else if (tick && wrap && busy) begin
            working <= shadow;
            busy    <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
    import pwm_pair_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    ch_cfg_t  [NCH-1:0]            cfg;
    pd_word_t [NCH-1:0]            shadow;
    logic     [NCH-1:0]            ch_we;
    logic     [NCH-1:0]            ch_busy;
    logic     [NCH-1:0]            ch_run;
    logic     [NCH-1:0]            ch_act;
    logic     [NCH-1:0]            ch_tick;
    logic     [NCH-1:0]            ch_bad;
    logic     [NCH-1:0][CNT_W-1:0] ch_cnt;
    logic     [NCH-1:0][CNT_W-1:0] ch_wkprd;

    pwm_pair_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (ch_busy),
        .pd_shadow (shadow),
        .cfg       (cfg),
        .pd_we     (ch_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic unused_spare;
        assign unused_spare = ^cfg[c].spare;
        assign ch_run[c]    = cfg[c].en && cfg[c].gate;
        assign ch_act[c]    = cfg[c].act;

        pwm_pair_presc u_presc (
            .clk      (clk),
            .rst      (rst),
            .run      (ch_run[c]),
            .code     (cfg[c].code),
            .tick     (ch_tick[c]),
            .bad_code (ch_bad[c])
        );

        pwm_pair_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .run      (ch_run[c]),
            .tick     (ch_tick[c]),
            .act      (ch_act[c]),
            .pd_we    (ch_we[c]),
            .pd_wdata (pd_word_t'(bus_wdata)),
            .shadow   (shadow[c]),
            .busy     (ch_busy[c]),
            .cnt      (ch_cnt[c]),
            .wk_prd   (ch_wkprd[c]),
            .pwm      (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            act,
    input logic [NCH-1:0]            busy,
    input logic [NCH-1:0]            bad,
    input logic [NCH-1:0]            we,
    input logic [NCH-1:0]            pwm,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] wk_prd
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_rest_level_r9: assert property (@(posedge clk) disable iff (rst)
            !run[g] |-> pwm[g] == !act[g]);

        p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
            !run[g] |=> cnt[g] == '0 && !busy[g]);

        p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (rst)
            cnt[g] <= wk_prd[g]);

        p_busy_set_r6: assert property (@(posedge clk) disable iff (rst)
            we[g] && run[g] |=> busy[g]);

        p_busy_until_wrap_r6: assert property (@(posedge clk) disable iff (rst)
            busy[g] && !we[g] |=> busy[g] || cnt[g] == '0);

        p_bad_code_stall_r10: assert property (@(posedge clk) disable iff (rst)
            run[g] && bad[g] |=> $stable(cnt[g]) || cnt[g] == '0);
    end

endmodule

bind pwm_pair_ctrl pwm_pair_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (ch_run),
    .act    (ch_act),
    .busy   (ch_busy),
    .bad    (ch_bad),
    .we     (ch_we),
    .pwm    (pwm_out),
    .cnt    (ch_cnt),
    .wk_prd (ch_wkprd)
);

// File: tb/test_pwm_pair_ctrl.sv
module test_pwm_pair_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_pair_ctrl i_pwm_pair_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic int ref_div(input int code);
        case (code)
            0: return 120;    1: return 180;    2: return 240;
            3: return 360;    4: return 480;    8: return 12000;
            9: return 24000;  10: return 36000; 11: return 48000;
            12: return 72000; 15: return 1;
            default: return 0;
        endcase
    endfunction

    int          m_field[2];
    logic [31:0] m_sh[2];
    logic [31:0] m_wk[2];
    bit          m_busy[2];
    int          m_pc[2];
    int          m_cnt[2];

    function automatic bit m_run(input int ch);
        return m_field[ch][4] && m_field[ch][6];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                m_field[ch] = 0; m_sh[ch] = 0; m_wk[ch] = 0;
                m_busy[ch] = 0; m_pc[ch] = 0; m_cnt[ch] = 0;
            end
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                bit run, tick, wrap, wr_pd;
                int d;
                run  = m_run(ch);
                d    = ref_div(m_field[ch] & 15);
                tick = run && d != 0 && m_pc[ch] >= d - 1;
                wrap = m_cnt[ch] == int'(m_wk[ch][31:16]);
                if (!run || d == 0 || tick) m_pc[ch] = 0; else m_pc[ch]++;
                wr_pd = bus_wr && int'(bus_addr[3:2]) == ch + 1;
                if (wr_pd) begin
                    m_sh[ch] = bus_wdata;
                    if (!run) begin m_wk[ch] = bus_wdata; m_busy[ch] = 0; end
                    else m_busy[ch] = 1;
                end else if (!run) begin
                    m_wk[ch] = m_sh[ch]; m_busy[ch] = 0;
                end else if (tick && wrap && m_busy[ch]) begin
                    m_wk[ch] = m_sh[ch]; m_busy[ch] = 0;
                end
                if (!run) m_cnt[ch] = 0;
                else if (tick) m_cnt[ch] = wrap ? 0 : m_cnt[ch] + 1;
            end
            if (bus_wr && bus_addr[3:2] == 2'd0)
                for (int ch = 0; ch < 2; ch++)
                    m_field[ch] = int'((bus_wdata >> (15 * ch)) & 32'h3FF);
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            logic [31:0] exp_rd;
            logic [1:0]  exp_out;
            for (int ch = 0; ch < 2; ch++) begin
                bit hit;
                hit = m_run(ch) && m_cnt[ch] < int'(m_wk[ch][15:0]);
                exp_out[ch] = m_field[ch][5] ? hit : !hit;
            end
            exp_rd = '0;
            if (bus_rd) begin
                if (bus_addr[3:2] == 2'd0)
                    exp_rd = 32'(m_field[0]) | (32'(m_field[1]) << 15)
                           | (32'(m_busy[0]) << 28) | (32'(m_busy[1]) << 29);
                else if (bus_addr[3:2] == 2'd1) exp_rd = m_sh[0];
                else if (bus_addr[3:2] == 2'd2) exp_rd = m_sh[1];
            end
            chk("R5 model output", 32'(pwm_out), 32'(exp_out));
            chk("R1 model readback", bus_rdata, exp_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            h += int'(pwm_out[ch]);
        end
    endtask

    task automatic count_toggles(input int ch, input int n, output int t);
        logic prev;
        t = 0;
        prev = pwm_out[ch];
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (pwm_out[ch] !== prev) t++;
            prev = pwm_out[ch];
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog (all R): got cycle %0d expected finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int h;
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R11: reset state
        #1 chk("R11 outputs after reset", 32'(pwm_out), 32'h3);
        rd(4'h0, v); chk("R11 ctrl after reset", v, 32'h0);
        rd(4'h4, v); chk("R11 ch0 word after reset", v, 32'h0);

        // R6: write while stopped loads at once, no pending flag
        wr(4'h4, {16'd4, 16'd2});
        rd(4'h0, v); chk("R6 no pending when stopped", v[28], 1'b0);
        rd(4'h4, v); chk("R1 ch0 word readback", v, {16'd4, 16'd2});

        // R5/R9: start bypass channel, first ticks are active
        wr(4'h0, 32'h7F);
        chk("R9 restart seq 0", 32'(pwm_out[0]), 32'd1);
        for (int i = 1; i < 5; i++) begin
            @(posedge clk); #1;
            chk("R5 bypass seq", 32'(pwm_out[0]), (i < 2) ? 32'd1 : 32'd0);
        end

        // R6: write lands on the wrap clock, stays pending a full period
        wr(4'h4, {16'd9, 16'd9});
        rd(4'h0, v); chk("R6 pending set", v[28], 1'b1);
        idle(3);
        rd(4'h0, v); chk("R6 still pending before next wrap", v[28], 1'b1);
        idle(10);
        rd(4'h0, v); chk("R6 pending cleared at wrap", v[28], 1'b0);
        count_high(0, 100, h); chk("R5 duty 9 of 10", 32'(h), 32'd90);

        // R7: full and zero duty
        wr(4'h4, {16'd4, 16'd5}); idle(14);
        count_high(0, 25, h); chk("R7 duty >= period", 32'(h), 32'd25);
        wr(4'h4, {16'd4, 16'd0}); idle(14);
        count_high(0, 25, h); chk("R7 duty zero", 32'(h), 32'd0);

        // R8: polarity
        wr(4'h4, {16'd4, 16'd2}); idle(14);
        wr(4'h0, 32'h5F);
        count_high(0, 50, h); chk("R8 inverted polarity", 32'(h), 32'd30);

        // R4: enable without gate, gate without enable
        wr(4'h0, 32'h3F);
        count_high(0, 20, h); chk("R4 no gate", 32'(h), 32'd0);
        wr(4'h0, 32'h6F);
        count_high(0, 20, h); chk("R4 no enable", 32'(h), 32'd0);

        // R9: stopped rests inactive, restart from zero
        wr(4'h0, 32'h2F);
        count_high(0, 20, h); chk("R9 rest level", 32'(h), 32'd0);
        wr(4'h0, 32'h7F);
        chk("R9 restart first tick", 32'(pwm_out[0]), 32'd1);
        for (int i = 1; i < 5; i++) begin
            @(posedge clk); #1;
            chk("R9 restart seq", 32'(pwm_out[0]), (i < 2) ? 32'd1 : 32'd0);
        end

        // R10: invalid code stalls output and pending value
        wr(4'h0, 32'h75);
        wr(4'h4, {16'd4, 16'd1});
        count_toggles(0, 40, h); chk("R10 output frozen", 32'(h), 32'd0);
        rd(4'h0, v); chk("R10 pending held", v[28], 1'b1);

        // R3/R2: channel 1 prescaler ratios, channel 0 stopped
        wr(4'h8, {16'd1, 16'd1});
        wr(4'h0, 32'h0); wr(4'h0, 32'h70 << 15);
        chk("R2 ch0 idle high", 32'(pwm_out[0]), 32'd1);
        count_high(1, 480, h); chk("R3 code 0 ratio 120", 32'(h), 32'd240);
        wr(4'h0, 32'h0); wr(4'h0, 32'h74 << 15);
        count_high(1, 1920, h); chk("R3 code 4 ratio 480", 32'(h), 32'd960);
        wr(4'h0, 32'h0); wr(4'h0, 32'h78 << 15);
        count_high(1, 48000, h); chk("R3 code 8 ratio 12000", 32'(h), 32'd24000);

        // R1: unmapped word, read strobe low
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); chk("R1 unmapped reads zero", v, 32'h0);
        rd(4'h0, v); chk("R1 unmapped write ignored", v, 32'h003C_0000);
        @(negedge clk) bus_rd = 1'b0;
        #1 chk("R1 rdata zero without strobe", bus_rdata, 32'h0);

        // R2: field layout and read-only pending bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R2 ctrl layout", v, 32'h01FF_83FF);

        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule